// File: doc/BRIEF.md
# Programmable Timer Time-Base Counter

This block is the counting core of a general-purpose timer. A free-running prescaler divides the clock by a programmable amount. Each time the prescaler wraps, the main counter takes one step up or down. When the main counter wraps it produces an update event. The counter width is a parameter; the same RTL serves both 16-bit and 32-bit timer instances.

Software programs the block through a simple write-only register port. A control register holds the run, direction, one-shot and trigger-select fields. Other registers hold the interrupt and DMA enables, the prescaler reload, the counter reload and a sticky update flag. A last register generates an update event from software.

Each update event can raise a one-cycle interrupt request, a one-cycle DMA request, or both, depending on the enables. A trigger output for other timers is taken from one of eight sources chosen by a 3-bit field. The sources are the block's own internal events and compare signals supplied from outside.

Top module: `tmr_timebase`

## Requirements
- R1: With the run bit (control address 0, bit 0) at 1 and the direction bit (control bit 1) at 0, the counter rises by one on each prescaler tick while it is below the reload value.
- R2: With control bit 1 at 1, the counter falls by one on each prescaler tick while it is above 0.
- R3: While the run bit is 0, the counter and the prescaler hold their values.
- R4: With prescaler reload P (address 2), the counter takes one step every P+1 clock cycles while running.
- R5: Counting up, a tick at a count equal to or above the reload value (address 3) sets the counter to 0 and produces an update event. Counting down, a tick at 0 loads the reload value and produces an update event.
- R6: With the one-shot bit (control bit 2) at 1, the run bit clears at the update event, and counting stops there.
- R7: The cycle after an update event, the interrupt request pulses high for one cycle only if address 1 bit 0 is set. The DMA request does the same only if address 1 bit 1 is set.
- R8: Writing 1 to bit 0 of address 5 restarts the prescaler at 0 and loads the counter (0 counting up, the reload value counting down). It also produces an update event in that same cycle.
- R9: The update flag sets on every update event and stays set. Writing 0 to bit 0 of address 4 clears it; writing 1 leaves it unchanged.
- R10: The trigger output is registered one cycle behind its source. Control bits 5:3 select the source: 0 software update pulse, 1 run bit, 2 update event, 3 compare pulse input, 4 to 7 compare reference inputs 0 to 3.
- R11: The counter width parameter CNT_W builds both a 16-bit and a 32-bit counter. The reload value and the count use the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| cmp_pulse | input | 1 | Compare pulse from a compare stage |
| cmp_ref | input | 4 | Compare reference levels, channels 0 to 3 |
| cnt_o | output | CNT_W | Current count |
| run_o | output | 1 | Current run bit |
| upd_flag_o | output | 1 | Sticky update flag |
| upd_irq_o | output | 1 | Update interrupt request pulse |
| upd_dma_o | output | 1 | Update DMA request pulse |
| trig_o | output | 1 | Selected trigger output |

## Verification
The bench checks the wrap cycle in both directions. A design that compared against the wrong limit would wrap one step early or late, or would land on the wrong value. It checks the prescaler period, so a divider off by one shows up as a step in the wrong cycle. It also checks that a one-shot run stops for good at its first update, and that a software update restarts the counter in the cycle of the write. Each gating enable, each of the eight trigger sources, the write-0-to-clear rule of the flag and a 32-bit instance are tested on their own. A swapped select code or an inverted clear would therefore give a wrong level at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_INTEN = 3'd1;
  localparam logic [ADDR_W-1:0] A_PSC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVGEN = 3'd5;

  typedef enum logic [2:0] {
    TRG_SWUPD  = 3'd0,
    TRG_RUN    = 3'd1,
    TRG_UPDATE = 3'd2,
    TRG_CMPPLS = 3'd3,
    TRG_REF0   = 3'd4,
    TRG_REF1   = 3'd5,
    TRG_REF2   = 3'd6,
    TRG_REF3   = 3'd7
  } trg_sel_e;

  typedef struct packed {
    trg_sel_e sel;
    logic     one_shot;
    logic     down;
    logic     run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] rld,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt;

  assign tick = run && (pcnt >= rld);

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (tick)      pcnt <= '0;
    else if (run)       pcnt <= pcnt + 1'b1;
  end

  // R4: between ticks the divider advances by exactly one
  a_r4_psc_step: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !tick) |=> (pcnt == $past(pcnt) + 1'b1));

  // R3: a stopped divider keeps its value
  a_r3_psc_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(pcnt));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  input  logic             down,
  input  logic [CNT_W-1:0] rld,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic at_limit;

  assign at_limit = down ? (cnt == '0) : (cnt >= rld);
  assign wrap     = tick && at_limit;

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (reload) cnt <= down ? rld : '0;
    else if (tick) begin
      if (down) cnt <= at_limit ? rld : cnt - 1'b1;
      else      cnt <= at_limit ? '0  : cnt + 1'b1;
    end
  end

  // R1: up step
  a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && !down && cnt < rld) |=> (cnt == $past(cnt) + 1'b1));

  // R2: down step
  a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && down && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5: wrap targets
  a_r5_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && !down && cnt >= rld) |=> (cnt == '0));
  a_r5_down_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && down && cnt == '0) |=> (cnt == $past(rld)));

  // R3: no tick, no reload, no change
  a_r3_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !reload) |=> $stable(cnt));
endmodule

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  trg_sel_e   sel,
  input  logic       sw_upd,
  input  logic       run,
  input  logic       upd_evt,
  input  logic       cmp_pulse,
  input  logic [3:0] cmp_ref,
  output logic       trig
);
  logic trig_d;

  always_comb begin
    case (sel)
      TRG_SWUPD:  trig_d = sw_upd;
      TRG_RUN:    trig_d = run;
      TRG_UPDATE: trig_d = upd_evt;
      TRG_CMPPLS: trig_d = cmp_pulse;
      default:    trig_d = cmp_ref[sel[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= trig_d;
  end

  // R10: in run mode the trigger follows the run bit one cycle later
  a_r10_run_follow: assert property (@(posedge clk) disable iff (rst)
    (sel == TRG_RUN) |=> (trig == $past(run)));

  // R10: in update mode the trigger is low unless an update happened
  a_r10_upd_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel == TRG_UPDATE && !upd_evt) |=> !trig);
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cmp_pulse,
  input  logic [3:0]        cmp_ref,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              run_o,
  output logic              upd_flag_o,
  output logic              upd_irq_o,
  output logic              upd_dma_o,
  output logic              trig_o
);
  ctrl_t            ctrl;
  logic             irq_en, dma_en;
  logic [PSC_W-1:0] psc_rld;
  logic [CNT_W-1:0] cnt_rld;
  logic             sw_upd, tick, wrap, upd_evt;
  logic             wr_ctrl, wr_stat;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign sw_upd  = wr_en && (wr_addr == A_EVGEN) && wr_data[0];
  assign upd_evt = wrap || sw_upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      irq_en  <= 1'b0;
      dma_en  <= 1'b0;
      psc_rld <= '0;
      cnt_rld <= '1;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      else if (upd_evt && ctrl.one_shot) ctrl.run <= 1'b0;
      if (wr_en && wr_addr == A_INTEN) begin
        irq_en <= wr_data[0];
        dma_en <= wr_data[1];
      end
      if (wr_en && wr_addr == A_PSC) psc_rld <= wr_data[PSC_W-1:0];
      if (wr_en && wr_addr == A_RLD) cnt_rld <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_flag_o <= 1'b0;
      upd_irq_o  <= 1'b0;
      upd_dma_o  <= 1'b0;
    end else begin
      upd_irq_o <= upd_evt && irq_en;
      upd_dma_o <= upd_evt && dma_en;
      if (upd_evt)                     upd_flag_o <= 1'b1;
      else if (wr_stat && !wr_data[0]) upd_flag_o <= 1'b0;
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(ctrl.run), .restart(sw_upd),
    .rld(psc_rld), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .reload(sw_upd),
    .down(ctrl.down), .rld(cnt_rld), .cnt(cnt_o), .wrap(wrap)
  );

  tmr_trig_mux u_trg (
    .clk(clk), .rst(rst), .sel(ctrl.sel), .sw_upd(sw_upd),
    .run(ctrl.run), .upd_evt(upd_evt), .cmp_pulse(cmp_pulse),
    .cmp_ref(cmp_ref), .trig(trig_o)
  );

  assign run_o = ctrl.run;

  // R6: one-shot stops the counter at the update event
  a_r6_one_shot_stop: assert property (@(posedge clk) disable iff (rst)
    (ctrl.one_shot && upd_evt && !wr_ctrl) |=> !run_o);

  // R7: gated requests
  a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !upd_irq_o);
  a_r7_dma_gate: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !upd_dma_o);

  // R9: flag stays set unless cleared by a zero write
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (upd_flag_o && !(wr_stat && !wr_data[0])) |=> upd_flag_o);

  // R11: supported widths
  initial begin
    a_r11_width: assert (CNT_W >= PSC_W && CNT_W >= CTRL_W);
  end
endmodule

// File: tb/test_tmr_timebase.sv
module test_tmr_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cmp_pulse = 1'b0;
  logic [3:0]  cmp_ref = '0;
  logic [15:0] cnt;
  logic        run, flag, irq, dma, trig;

  logic        w32_en = 1'b0;
  logic [2:0]  w32_addr = '0;
  logic [31:0] w32_data = '0;
  logic [31:0] cnt32;
  logic        run32, flag32, irq32, dma32, trig32;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  tmr_timebase #(.CNT_W(16), .PSC_W(16)) i_tmr_timebase (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_pulse(cmp_pulse), .cmp_ref(cmp_ref), .cnt_o(cnt), .run_o(run),
    .upd_flag_o(flag), .upd_irq_o(irq), .upd_dma_o(dma), .trig_o(trig)
  );

  tmr_timebase #(.CNT_W(32), .PSC_W(16)) i_tmr_timebase_w32 (
    .clk(clk), .rst(rst), .wr_en(w32_en), .wr_addr(w32_addr), .wr_data(w32_data),
    .cmp_pulse(1'b0), .cmp_ref(4'b0), .cnt_o(cnt32), .run_o(run32),
    .upd_flag_o(flag32), .upd_irq_o(irq32), .upd_dma_o(dma32), .trig_o(trig32)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr32(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    w32_en = 1'b1; w32_addr = a; w32_data = d;
    @(negedge clk);
    w32_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop, program reloads, restart from a software update, leave stopped
  task automatic setup(input logic [15:0] ctl, input logic [15:0] psc, input logic [15:0] rld);
    wr(3'd0, ctl & 16'hFFFE);
    wr(3'd2, psc);
    wr(3'd3, rld);
    wr(3'd5, 16'd1);
  endtask

  task automatic t_reset;
    check("R3 reset cnt", cnt, 0);
    check("R9 reset flag", flag, 0);
    check("R7 reset irq", irq, 0);
    check("R10 reset trig", trig, 0);
    check("R11 reset cnt32", cnt32, 0);
  endtask

  task automatic t_up_wrap;
    wr(3'd1, 16'd1);
    setup(16'd0, 16'd0, 16'd3);
    wr(3'd0, 16'd1);
    check("R1 start", cnt, 0);
    step(1); check("R1 step1", cnt, 1);
    step(2); check("R1 step3", cnt, 3);
    check("R7 no irq before wrap", irq, 0);
    step(1); check("R5 up wrap to 0", cnt, 0);
    check("R7 irq on wrap", irq, 1);
    step(1); check("R7 irq one cycle", irq, 0);
    check("R1 after wrap", cnt, 1);
  endtask

  task automatic t_hold;
    logic [15:0] held;
    wr(3'd0, 16'd0);
    held = cnt;
    step(5);
    check("R3 hold while stopped", cnt, {16'd0, held});
  endtask

  task automatic t_down;
    setup(16'd2, 16'd0, 16'd3);
    check("R8 down reload value", cnt, 3);
    wr(3'd0, 16'd3);
    step(1); check("R2 down step", cnt, 2);
    step(2); check("R2 reach 0", cnt, 0);
    step(1); check("R5 down wrap to reload", cnt, 3);
    check("R7 irq on down wrap", irq, 1);
  endtask

  task automatic t_psc;
    setup(16'd0, 16'd2, 16'd10);
    wr(3'd0, 16'd1);
    step(2); check("R4 no step before P+1", cnt, 0);
    step(1); check("R4 first step", cnt, 1);
    step(2); check("R4 mid period", cnt, 1);
    step(1); check("R4 second step", cnt, 2);
  endtask

  task automatic t_one_shot;
    setup(16'd0, 16'd0, 16'd2);
    wr(3'd0, 16'd5);
    step(2); check("R6 running", cnt, 2);
    step(1); check("R6 wrapped", cnt, 0);
    check("R6 run cleared", run, 0);
    step(3); check("R6 stays stopped", cnt, 0);
  endtask

  task automatic t_sw_update;
    wr(3'd1, 16'd1);
    setup(16'd0, 16'd0, 16'd10);
    wr(3'd0, 16'd1);
    step(4);
    check("R8 before", cnt, 4);
    wr(3'd5, 16'd1);
    check("R8 counter restarted", cnt, 0);
    check("R8 irq from sw update", irq, 1);
    check("R10 sel0 pulse", trig, 1);
    step(1);
    check("R8 counts on", cnt, 1);
    check("R10 sel0 pulse ends", trig, 0);
    wr(3'd5, 16'd0);
    check("R8 zero write no reload", cnt, 3);
  endtask

  task automatic t_flag;
    wr(3'd0, 16'd0);
    wr(3'd5, 16'd1);
    step(2);
    check("R9 flag sticky", flag, 1);
    wr(3'd4, 16'd1);
    check("R9 write 1 keeps", flag, 1);
    wr(3'd4, 16'd0);
    check("R9 write 0 clears", flag, 0);
  endtask

  task automatic t_gating;
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd2);
    wr(3'd5, 16'd1);
    check("R7 dma only: dma", dma, 1);
    check("R7 dma only: irq", irq, 0);
    wr(3'd1, 16'd1);
    wr(3'd5, 16'd1);
    check("R7 irq only: irq", irq, 1);
    check("R7 irq only: dma", dma, 0);
    wr(3'd1, 16'd0);
    wr(3'd5, 16'd1);
    check("R7 none: irq", irq, 0);
    check("R7 none: dma", dma, 0);
  endtask

  task automatic t_trig;
    wr(3'd0, 16'd8 | 16'd1);
    step(1); check("R10 sel1 run high", trig, 1);
    wr(3'd0, 16'd8);
    step(1); check("R10 sel1 run low", trig, 0);
    wr(3'd0, 16'd16);
    wr(3'd5, 16'd1);
    check("R10 sel2 update", trig, 1);
    step(1); check("R10 sel2 quiet", trig, 0);
    wr(3'd0, 16'd24);
    cmp_pulse = 1'b1;
    step(1); check("R10 sel3 pulse high", trig, 1);
    cmp_pulse = 1'b0;
    step(1); check("R10 sel3 pulse low", trig, 0);
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, 16'((4 + i) << 3));
      cmp_ref = 4'(1 << i);
      step(1); check("R10 ref selected high", trig, 1);
      cmp_ref = ~4'(1 << i);
      step(1); check("R10 ref selected low", trig, 0);
    end
    cmp_ref = '0;
  endtask

  task automatic t_w32;
    wr32(3'd0, 32'd2);
    wr32(3'd3, 32'h1234_5678);
    wr32(3'd5, 32'd1);
    check("R11 32-bit reload", cnt32, 32'h1234_5678);
    wr32(3'd0, 32'd3);
    step(1);
    check("R11 32-bit down step", cnt32, 32'h1234_5677);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(1);
    t_reset();
    t_up_wrap();
    t_hold();
    t_down();
    t_psc();
    t_one_shot();
    t_sw_update();
    t_flag();
    t_gating();
    t_trig();
    t_w32();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule